// File: doc/BRIEF.md
# I2C 10-bit Slave Address Matcher

This block decides whether an I2C slave with a 10-bit own address has been selected. It sits behind a bit-level receiver and a bus condition detector: the receiver strobes each complete byte in on `rx_valid` with `rx_byte`, and the detector pulses `start_pulse`, `restart_pulse` and `stop_pulse` when it sees those conditions on the bus. From these it works out whether the address phase selected this slave, and in which direction.

A write selection takes two address bytes. The first is a header byte that carries the two upper address bits. The second carries the lower eight bits. Once both have matched, a remembered-selection flag (`prior_match`) is set. While that flag is set, the master can issue a Restart and send the header byte again with the read bit set. That header byte alone selects the slave for reading, and the block then raises `hold_req` so that the data path can stretch the clock and get the first byte ready to send.

The FSM states are: `ST_IDLE` (no transfer; bytes are ignored), `ST_HDR` (waiting for the header byte), `ST_LOW` (header matched with write; waiting for the low byte), `ST_DATA_W` (fully addressed for a write; further bytes are data and are ignored), `ST_READ` (selected for reading; clock hold requested) and `ST_SKIP` (not addressed; bytes are ignored). The transitions are:
- Stop from any state goes to `ST_IDLE`.
- Start or Restart from any state goes to `ST_HDR`.
- In `ST_HDR`, a matching header byte with write goes to `ST_LOW`.
- In `ST_HDR`, a matching header byte with read goes to `ST_READ` when `prior_match` is set, and to `ST_SKIP` when it is clear.
- In `ST_HDR`, a header byte that does not match goes to `ST_SKIP`.
- In `ST_LOW`, a matching low byte goes to `ST_DATA_W`, and a low byte that does not match goes to `ST_SKIP`.

Top module: `tba_addr10_match`

## Requirements
- R1: After reset, `match_pulse`, `dir_read`, `hold_req` and `prior_match` are all 0. Bytes received before any Start or Restart are ignored.
- R2: A header byte has the form 11110, then address bit 9, then address bit 8, with the read bit in bit 0 (1 = read). In `ST_HDR`, a matching header byte with bit 0 = 0, followed by a low byte equal to `own_addr[7:0]`, gives `match_pulse` the cycle after the low byte is strobed. In that cycle `dir_read` = 0 and `prior_match` = 1.
- R3: A low byte that differs from `own_addr[7:0]` gives no match and leaves `prior_match` at 0. Bytes after it are ignored until the next Start or Restart.
- R4: While `prior_match` = 1, a Restart followed by a matching header byte with bit 0 = 1 gives `match_pulse` with `dir_read` = 1 and `hold_req` = 1, without any low byte.
- R5: A matching header byte with bit 0 = 1 while `prior_match` = 0 gives no match and no `hold_req`. The transfer is ignored after it.
- R6: A Stop clears `prior_match` on the next cycle.
- R7: Any header byte with bit 0 = 0 clears `prior_match`, whether or not it matches.
- R8: A header byte that fails to match clears `prior_match`. This covers a wrong 11110 prefix and wrong upper address bits.
- R9: A Start or Restart returns the address logic to waiting for a header byte, and discards any partially received address.
- R10: `dir_read` and `hold_req` keep their values until the next Start, Restart or Stop, which clears both.
- R11: `match_pulse` lasts exactly one cycle.
- R12: Once fully addressed for a write, bytes that follow, including one equal to the low address, give no further `match_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| own_addr | input | 10 | Own 10-bit slave address |
| rx_valid | input | 1 | One-cycle strobe: a received byte is on rx_byte |
| rx_byte | input | 8 | Received byte |
| start_pulse | input | 1 | Start condition detected |
| restart_pulse | input | 1 | Restart condition detected |
| stop_pulse | input | 1 | Stop condition detected |
| match_pulse | output | 1 | One-cycle pulse when the slave is selected |
| dir_read | output | 1 | Direction of the selection (1 = slave transmits) |
| hold_req | output | 1 | Request to hold the clock low for a read |
| prior_match | output | 1 | Remembered full write selection |

## Verification
Several properties are checked on every cycle. `match_pulse` never lasts two cycles. `hold_req` only appears together with `dir_read`. Every selection, read or write, is accompanied by a set `prior_match`. A Stop always clears the flag and the read selection. The direction bit stays put until a bus condition arrives. Only the bench's scenarios can show the rest: which byte sequences match and which do not, each of the three events that clear the flag, and that bytes outside the address phase are ignored.

// File: rtl/tba_pkg.sv
package tba_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_LOW,
        ST_DATA_W,
        ST_READ,
        ST_SKIP
    } tba_state_e;

    localparam logic [4:0] HDR_PREFIX = 5'b11110;

    typedef struct packed {
        logic form_ok;   // top bits carry the 10-bit header prefix
        logic upper_ok;  // upper address bits equal own address
        logic rw;        // read bit of the header
    } hdr_info_t;

endpackage

// File: rtl/tba_hdr_decode.sv
module tba_hdr_decode
    import tba_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int BYTE_W = 8
) (
    input  logic [BYTE_W-1:0]        byte_i,
    input  logic [ADDR_W-BYTE_W-1:0] own_upper_i,
    input  logic [BYTE_W-1:0]        own_lower_i,
    output hdr_info_t                hdr_o,
    output logic                     low_ok_o
);
    localparam int HI_W  = ADDR_W - BYTE_W;
    localparam int PFX_W = BYTE_W - HI_W - 1;

    always_comb begin
        hdr_o.form_ok  = (byte_i[BYTE_W-1 -: PFX_W] == HDR_PREFIX[4 -: PFX_W]);
        hdr_o.upper_ok = (byte_i[HI_W:1] == own_upper_i);
        hdr_o.rw       = byte_i[0];
        low_ok_o       = (byte_i == own_lower_i);
    end
endmodule

// File: rtl/tba_prior_flag.sv
module tba_prior_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    always_ff @(posedge clk) begin
        if (!rst_n)      flag_o <= 1'b0;
        else if (clr_i)  flag_o <= 1'b0;
        else if (set_i)  flag_o <= 1'b1;
    end
endmodule

// File: rtl/tba_fsm.sv
module tba_fsm
    import tba_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      byte_valid_i,
    input  hdr_info_t hdr_i,
    input  logic      low_ok_i,
    input  logic      begin_i,
    input  logic      stop_i,
    input  logic      prior_i,
    output logic      prior_set_o,
    output logic      prior_clr_o,
    output logic      match_o,
    output logic      dir_o,
    output logic      hold_o
);
    tba_state_e state_q, state_d;
    logic sel_write, sel_read;

    // next state and flag strobes
    always_comb begin
        state_d     = state_q;
        prior_set_o = 1'b0;
        prior_clr_o = stop_i;
        sel_write   = 1'b0;
        sel_read    = 1'b0;
        if (stop_i) begin
            state_d = ST_IDLE;
        end else if (begin_i) begin
            state_d = ST_HDR;
        end else if (byte_valid_i) begin
            unique case (state_q)
                ST_HDR: begin
                    if (!(hdr_i.form_ok && hdr_i.upper_ok)) begin
                        state_d     = ST_SKIP;
                        prior_clr_o = 1'b1;
                    end else if (!hdr_i.rw) begin
                        state_d     = ST_LOW;
                        prior_clr_o = 1'b1;
                    end else if (prior_i) begin
                        state_d  = ST_READ;
                        sel_read = 1'b1;
                    end else begin
                        state_d = ST_SKIP;
                    end
                end
                ST_LOW: begin
                    if (low_ok_i) begin
                        state_d     = ST_DATA_W;
                        prior_set_o = 1'b1;
                        sel_write   = 1'b1;
                    end else begin
                        state_d = ST_SKIP;
                    end
                end
                ST_IDLE, ST_DATA_W, ST_READ, ST_SKIP: state_d = state_q;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_o <= 1'b0;
            dir_o   <= 1'b0;
        end else begin
            match_o <= sel_write | sel_read;
            if (stop_i || begin_i) dir_o <= 1'b0;
            else if (sel_read)     dir_o <= 1'b1;
        end
    end

    assign hold_o = (state_q == ST_READ);
endmodule

// File: rtl/tba_addr10_match.sv
module tba_addr10_match
    import tba_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              start_pulse,
    input  logic              restart_pulse,
    input  logic              stop_pulse,
    output logic              match_pulse,
    output logic              dir_read,
    output logic              hold_req,
    output logic              prior_match
);
    hdr_info_t hdr;
    logic      low_ok, p_set, p_clr;

    tba_hdr_decode #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_dec (
        .byte_i      (rx_byte),
        .own_upper_i (own_addr[ADDR_W-1:BYTE_W]),
        .own_lower_i (own_addr[BYTE_W-1:0]),
        .hdr_o       (hdr),
        .low_ok_o    (low_ok)
    );

    tba_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .byte_valid_i (rx_valid),
        .hdr_i        (hdr),
        .low_ok_i     (low_ok),
        .begin_i      (start_pulse | restart_pulse),
        .stop_i       (stop_pulse),
        .prior_i      (prior_match),
        .prior_set_o  (p_set),
        .prior_clr_o  (p_clr),
        .match_o      (match_pulse),
        .dir_o        (dir_read),
        .hold_o       (hold_req)
    );

    tba_prior_flag u_prior (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (p_set),
        .clr_i  (p_clr),
        .flag_o (prior_match)
    );

    assert_pulse_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        match_pulse |=> !match_pulse);

    assert_hold_is_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hold_req |-> dir_read);

    assert_match_has_prior_R2: assert property (@(posedge clk) disable iff (!rst_n)
        match_pulse |-> prior_match);

    assert_stop_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stop_pulse |=> (!prior_match && !hold_req && !dir_read));

    assert_dir_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_read && !stop_pulse && !start_pulse && !restart_pulse) |=> dir_read);
endmodule

// File: tb/tba_addr10_match_tb.sv
`timescale 1ns/1ps
module tba_addr10_match_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] own_addr = 10'h2CA;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       start_pulse = 1'b0, restart_pulse = 1'b0, stop_pulse = 1'b0;
    logic       match_pulse, dir_read, hold_req, prior_match;
    int checks = 0, failures = 0;

    localparam logic [7:0] HW = 8'hF4; // 11110_10_0
    localparam logic [7:0] HR = 8'hF5; // 11110_10_1
    localparam logic [7:0] LO = 8'hCA;

    always #4 clk = ~clk;

    tba_addr10_match u_dut (.*);

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    // each helper leaves time at a negedge with outputs of the last edge visible
    task automatic send(input logic [7:0] b);
        @(negedge clk); rx_valid = 1'b1; rx_byte = b;
        @(negedge clk); rx_valid = 1'b0;
    endtask
    task automatic cond_start();
        @(negedge clk); start_pulse = 1'b1;
        @(negedge clk); start_pulse = 1'b0;
    endtask
    task automatic cond_restart();
        @(negedge clk); restart_pulse = 1'b1;
        @(negedge clk); restart_pulse = 1'b0;
    endtask
    task automatic cond_stop();
        @(negedge clk); stop_pulse = 1'b1;
        @(negedge clk); stop_pulse = 1'b0;
    endtask
    task automatic full_write();
        cond_start(); send(HW); send(LO);
    endtask

    task automatic t_reset();
        chk("R1", "match_pulse", match_pulse, 1'b0);
        chk("R1", "dir_read", dir_read, 1'b0);
        chk("R1", "hold_req", hold_req, 1'b0);
        chk("R1", "prior_match", prior_match, 1'b0);
        send(HW); send(LO);
        chk("R1", "no match before start", match_pulse, 1'b0);
        chk("R1", "prior before start", prior_match, 1'b0);
    endtask

    task automatic t_write_match();
        cond_start(); send(HW);
        chk("R2", "no match on header", match_pulse, 1'b0);
        send(LO);
        chk("R2", "match_pulse", match_pulse, 1'b1);
        chk("R2", "dir_read", dir_read, 1'b0);
        chk("R2", "prior_match", prior_match, 1'b1);
        @(negedge clk);
        chk("R11", "pulse one cycle", match_pulse, 1'b0);
        send(LO);
        chk("R12", "data byte no match", match_pulse, 1'b0);
    endtask

    task automatic t_read_restart();
        cond_restart(); send(HR);
        chk("R4", "match_pulse", match_pulse, 1'b1);
        chk("R4", "dir_read", dir_read, 1'b1);
        chk("R4", "hold_req", hold_req, 1'b1);
        chk("R4", "prior kept", prior_match, 1'b1);
        repeat (3) @(negedge clk);
        chk("R10", "dir held", dir_read, 1'b1);
        chk("R10", "hold held", hold_req, 1'b1);
        cond_restart();
        chk("R10", "dir cleared", dir_read, 1'b0);
        chk("R10", "hold cleared", hold_req, 1'b0);
    endtask

    task automatic t_stop();
        cond_stop();
        chk("R6", "prior after stop", prior_match, 1'b0);
        cond_start(); send(HR);
        chk("R5", "read after stop no match", match_pulse, 1'b0);
    endtask

    task automatic t_read_no_prior();
        cond_start(); send(HR);
        chk("R5", "match_pulse", match_pulse, 1'b0);
        chk("R5", "hold_req", hold_req, 1'b0);
        chk("R5", "dir_read", dir_read, 1'b0);
        send(LO);
        chk("R5", "later byte ignored", match_pulse, 1'b0);
    endtask

    task automatic t_low_mismatch();
        cond_start(); send(HW); send(8'hCB);
        chk("R3", "match_pulse", match_pulse, 1'b0);
        chk("R3", "prior_match", prior_match, 1'b0);
        send(LO);
        chk("R3", "later byte ignored", match_pulse, 1'b0);
    endtask

    task automatic t_write_hdr_clears();
        full_write();
        chk("R7", "prior set first", prior_match, 1'b1);
        cond_restart(); send(HW);
        chk("R7", "prior cleared", prior_match, 1'b0);
        cond_restart(); send(HR);
        chk("R7", "read refused", match_pulse, 1'b0);
    endtask

    task automatic t_bad_hdr_clears();
        full_write(); cond_restart(); send(8'hF7); // upper bits 11
        chk("R8", "upper mismatch clears", prior_match, 1'b0);
        full_write(); cond_restart(); send(8'hB5); // wrong prefix
        chk("R8", "prefix mismatch clears", prior_match, 1'b0);
        chk("R8", "no match", match_pulse, 1'b0);
    endtask

    task automatic t_restart_midway();
        cond_stop();
        cond_start(); send(HW); cond_restart(); send(LO);
        chk("R9", "low byte taken as header", match_pulse, 1'b0);
        cond_restart(); send(HW); send(LO);
        chk("R9", "fresh address matches", match_pulse, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_match();
        t_read_restart();
        t_stop();
        t_read_no_prior();
        t_low_mismatch();
        t_write_hdr_clears();
        t_bad_hdr_clears();
        t_restart_midway();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule